// File: doc/BRIEF.md
# Single-Bank Row-Buffer Access Sequencer

This block stands in for one DRAM bank that can hold one open row in its row buffer. A requester offers one read or write at a time with a valid/ready handshake. Each request carries a row index and a column index. At acceptance the block compares the requested row with the row buffer's contents and sorts the request into one of three classes:

- **hit**: the row is already open.
- **empty miss**: no row is open.
- **conflict miss**: a different row is open.

The block then emits the abstract command pulses the class needs: precharge, activate and column access. Every command phase lasts a fixed, parameterised number of cycles. The block ends the request with a one-cycle completion pulse that carries the class code. After the access the row is left open, so a run of accesses to the same row pays only the column phase.

The cost of a request depends on the state the previous requests left behind. A hit takes one phase, an empty miss takes two and a conflict miss takes three.

Top module: `bank_row_ctrl`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, no command or completion pulse is asserted, and the bank holds no open row, so the first request completes with class code 1.
- R2: A request to the open row completes with class code 0. It issues exactly one cmd_col pulse, in the first cycle after acceptance, and no precharge or activate. done_valid rises PHASE_CYC cycles after the accepting edge.
- R3: A request while no row is open completes with class code 1. It issues cmd_act in the first cycle after acceptance and cmd_col PHASE_CYC cycles later, with no precharge. done_valid rises 2*PHASE_CYC cycles after the accepting edge.
- R4: A request to a row other than the open one completes with class code 2. It issues cmd_pre, cmd_act and cmd_col in that order, PHASE_CYC cycles apart, starting in the first cycle after acceptance. done_valid rises 3*PHASE_CYC cycles after the accepting edge. A precharge is never issued while no row is open.
- R5: When an activate phase ends, the activated row becomes the open row. It stays open after the column access, so the next request to it is a hit.
- R6: req_ready is 0 from the accepting edge until done_valid rises, and is 1 in that cycle. A request offered while req_ready is 0 is ignored: it issues no command and does not change the open row.
- R7: done_valid is a one-cycle pulse and done_class is never 3.
- R8: At most one of cmd_pre, cmd_act and cmd_col is high in any cycle, and each is a one-cycle pulse per phase. cmd_row carries the request's row during cmd_act. cmd_col_addr and cmd_write carry the request's column and direction during cmd_col.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Requested row index |
| req_col | input | COL_W | Requested column index |
| cmd_pre | output | 1 | Precharge command pulse |
| cmd_act | output | 1 | Row activate command pulse |
| cmd_col | output | 1 | Column access command pulse |
| cmd_write | output | 1 | Direction of the column access |
| cmd_row | output | ROW_W | Row of the request in service |
| cmd_col_addr | output | COL_W | Column of the request in service |
| done_valid | output | 1 | Completion pulse |
| done_class | output | 2 | 0 hit, 1 empty miss, 2 conflict miss |

## Verification
The hardest situation to reach is a conflict miss that follows a completed write, since it needs an open row that a previous request left behind. It also matters what happens to a request offered while the bank is still busy.

The bench sweeps every ordered pair of rows over a small row space, so every transition between open-row states is covered. A reference row-buffer model in the bench predicts the class of each request and the exact cycle of each command pulse. Some requests also raise req_valid with a different row partway through a busy period. The following request is then checked to confirm that the busy-period request left no trace.

// File: rtl/bank_ctrl_pkg.sv
// Shared types for the bank row-buffer sequencer.
// Assumes: class codes are fixed by the completion interface (0/1/2).
package bank_ctrl_pkg;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_EMPTY    = 2'd1,
        CLS_CONFLICT = 2'd2
    } access_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_ACT  = 2'd2,
        ST_COL  = 2'd3
    } bank_state_e;

endpackage

// File: rtl/bank_row_classifier.sv
// Sorts an incoming row against the row-buffer contents.
// Assumes: open_row_i is meaningful only when open_valid_i is set.
module bank_row_classifier
    import bank_ctrl_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             open_valid_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [ROW_W-1:0] req_row_i,
    output access_class_e    class_o
);

    // Pick hit, empty miss or conflict miss from the buffer state.
    always_comb begin
        if (!open_valid_i) begin
            class_o = CLS_EMPTY;
        end else if (open_row_i == req_row_i) begin
            class_o = CLS_HIT;
        end else begin
            class_o = CLS_CONFLICT;
        end
    end

endmodule

// File: rtl/bank_open_row.sv
// Holds which row, if any, is latched in the row buffer.
// Assumes: close and open requests come from distinct phase ends
// and never coincide.
module bank_open_row #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_i,
    input  logic             open_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             valid_o,
    output logic [ROW_W-1:0] row_o
);

    // Track buffer contents: cleared on precharge end, loaded on activate end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            row_o   <= '0;
        end else if (close_i) begin
            valid_o <= 1'b0;
        end else if (open_i) begin
            valid_o <= 1'b1;
            row_o   <= row_i;
        end
    end

    // R5
    open_close_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_i && close_i));

endmodule

// File: rtl/bank_phase_timer.sv
// Counts one command phase of PHASE_CYC cycles.
// Assumes: start_i is raised on the edge that begins a phase; the
// owner ignores first_o/last_o while no phase is running.
module bank_phase_timer #(
    parameter int PHASE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic first_o,
    output logic last_o
);

    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fresh_q;

    // Load on phase start, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fresh_q <= 1'b0;
        end else if (start_i) begin
            cnt_q   <= LOAD_V;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign first_o = fresh_q;
    assign last_o  = (cnt_q == '0);

endmodule

// File: rtl/bank_row_ctrl.sv
// Top of the single-bank row-buffer sequencer. Accepts one request
// at a time, classifies it against the open row, walks through the
// needed precharge/activate/column phases and signals completion.
// Assumes: open-page policy; each phase costs PHASE_CYC cycles.
module bank_row_ctrl
    import bank_ctrl_pkg::*;
#(
    parameter int ROW_W     = 8,
    parameter int COL_W     = 6,
    parameter int PHASE_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             cmd_pre,
    output logic             cmd_act,
    output logic             cmd_col,
    output logic             cmd_write,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col_addr,
    output logic             done_valid,
    output logic [1:0]       done_class
);

    bank_state_e      state_q, state_d;
    access_class_e    cls_now;
    logic [1:0]       class_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             write_q;
    logic             done_q;
    logic             open_valid;
    logic [ROW_W-1:0] open_row;
    logic             tmr_start, tmr_first, tmr_last;
    logic             accept, phase_end;

    bank_row_classifier #(.ROW_W(ROW_W)) classify_i (
        .open_valid_i (open_valid),
        .open_row_i   (open_row),
        .req_row_i    (req_row),
        .class_o      (cls_now)
    );

    bank_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .first_o (tmr_first),
        .last_o  (tmr_last)
    );

    bank_open_row #(.ROW_W(ROW_W)) rowbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .close_i (phase_end && (state_q == ST_PRE)),
        .open_i  (phase_end && (state_q == ST_ACT)),
        .row_i   (row_q),
        .valid_o (open_valid),
        .row_o   (open_row)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign phase_end = (state_q != ST_IDLE) && tmr_last && !tmr_first
                       || (state_q != ST_IDLE) && tmr_last && (PHASE_CYC == 1);
    assign tmr_start = accept || (phase_end && (state_q != ST_COL));

    // Choose the next phase from the class or the finished phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                unique case (cls_now)
                    CLS_HIT:   state_d = ST_COL;
                    CLS_EMPTY: state_d = ST_ACT;
                    default:   state_d = ST_PRE;
                endcase
            end
            ST_PRE:  if (phase_end) state_d = ST_ACT;
            ST_ACT:  if (phase_end) state_d = ST_COL;
            ST_COL:  if (phase_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Advance the phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the request fields and class on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            write_q <= 1'b0;
            class_q <= 2'd0;
        end else if (accept) begin
            row_q   <= req_row;
            col_q   <= req_col;
            write_q <= req_write;
            class_q <= 2'(cls_now);
        end
    end

    // Raise the completion pulse for one cycle as the column phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= phase_end && (state_q == ST_COL);
        end
    end

    assign cmd_pre      = (state_q == ST_PRE) && tmr_first;
    assign cmd_act      = (state_q == ST_ACT) && tmr_first;
    assign cmd_col      = (state_q == ST_COL) && tmr_first;
    assign cmd_write    = write_q;
    assign cmd_row      = row_q;
    assign cmd_col_addr = col_q;
    assign done_valid   = done_q;
    assign done_class   = class_q;

    // R8
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre, cmd_act, cmd_col}));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R7
    done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_class != 2'd3));

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    pre_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |-> open_valid);

    // R2
    act_not_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && $past(req_ready)) |-> !open_valid);

endmodule

// File: tb/bank_row_ctrl_tb_top.sv
// Bench: sweeps every ordered row pair against a reference row-buffer
// model and checks class, command timing, fields and handshake.
module bank_row_ctrl_tb_top;

    localparam int ROW_W = 2;
    localparam int COL_W = 3;
    localparam int P     = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             cmd_pre, cmd_act, cmd_col, cmd_write;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col_addr;
    logic             done_valid;
    logic [1:0]       done_class;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model of the row buffer
    bit             m_open = 0;
    int             m_row = 0;

    always #2.5 clk = ~clk;

    bank_row_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .PHASE_CYC(P)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col),
        .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
        .cmd_write(cmd_write), .cmd_row(cmd_row), .cmd_col_addr(cmd_col_addr),
        .done_valid(done_valid), .done_class(done_class)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input int row, input int col, input bit wr, input bit busy);
        int cls, n, c;
        int pre_at, act_at, col_at, done_at, dcls;
        int npre, nact, ncol, ndone, busy_ready, act_row, col_addr, col_wr;
        cls = !m_open ? 1 : ((m_row == row) ? 0 : 2);
        n = cls + 1;
        pre_at = -1; act_at = -1; col_at = -1; done_at = -1; dcls = -1;
        npre = 0; nact = 0; ncol = 0; ndone = 0; busy_ready = 0;
        act_row = -1; col_addr = -1; col_wr = -1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_write = wr;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        for (c = 0; c <= n * P; c++) begin
            if (cmd_pre) begin npre++; pre_at = c; end
            if (cmd_act) begin nact++; act_at = c; act_row = int'(cmd_row); end
            if (cmd_col) begin
                ncol++; col_at = c; col_addr = int'(cmd_col_addr); col_wr = int'(cmd_write);
            end
            if (done_valid) begin ndone++; done_at = c; dcls = int'(done_class); end
            if (c < n * P && req_ready) busy_ready++;
            if (busy && c == 1) begin
                req_valid = 1'b1;
                req_row   = ROW_W'(row ^ 1);
            end
            if (busy && c == 2) req_valid = 1'b0;
            if (c < n * P) begin
                @(posedge clk);
                #1;
            end
        end
        // R2 R3 R4: class code and latency
        chk(dcls == cls, "R2/R3/R4 class", dcls, cls);
        chk(ndone == 1 && done_at == n * P, "R7 done timing", done_at, n * P);
        chk(npre == (cls == 2 ? 1 : 0) && pre_at == (cls == 2 ? 0 : -1),
            "R4 precharge at", pre_at, (cls == 2 ? 0 : -1));
        chk(nact == (cls == 0 ? 0 : 1) && act_at == (cls == 2 ? P : (cls == 1 ? 0 : -1)),
            "R3 activate at", act_at, (cls == 2 ? P : (cls == 1 ? 0 : -1)));
        chk(ncol == 1 && col_at == (n - 1) * P, "R2 column at", col_at, (n - 1) * P);
        if (cls != 0) chk(act_row == row, "R8 cmd_row", act_row, row);
        chk(col_addr == col && col_wr == int'(wr), "R8 column fields", col_addr, col);
        chk(busy_ready == 0, "R6 ready low while busy", busy_ready, 0);
        chk(req_ready == 1'b1, "R6 ready at done", int'(req_ready), 1);
        m_open = 1;
        m_row  = row;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: idle state after reset
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk({cmd_pre, cmd_act, cmd_col, done_valid} == 4'b0, "R1 quiet",
            int'({cmd_pre, cmd_act, cmd_col, done_valid}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first request sees an empty bank (class 1)
        do_req(2, 5, 1'b0, 1'b0);
        // R5: same row again is a hit
        do_req(2, 1, 1'b1, 1'b0);
        // sweep all ordered row pairs; R5 open page across the pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_req(a, (a * 4 + b) % 8, bit'(b & 1), 1'b0);
                do_req(b, (a + b * 3) % 8, bit'(a & 1), bit'((a + b) % 3 == 0));
            end
        end
        // R6: request offered while busy is ignored; next same-row access hits
        do_req(1, 3, 1'b1, 1'b1);
        do_req(1, 4, 1'b0, 1'b0);
        // R5 reset returns bank to empty
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_open = 0;
        do_req(1, 0, 1'b0, 1'b0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule